// File: doc/BRIEF.md
# Serial-Loaded Motor Channel Enable Interface

This block generates the eight output-transistor enables for a four-phase unipolar motor driver. Each phase (A, B, C, D) has a plus and a minus side. A mode input selects where the enables come from. In parallel mode, eight direct inputs switch the eight enables one to one. In serial mode, a byte is shifted in on a serial clock and data pair. A latch input then copies it into a storage register, and the storage register drives the enables.

All pins arrive as synchronous samples in the system clock domain. They pass through one register stage. Rising edges of the serial clock and of the latch are found by comparing that registered sample with the sample before it. A gate input masks the serial-mode enables. A standby input forces every enable off in both modes. The clear input acts on the storage register only. The enables leave the block through an output register.

Top module: `motor_enable_if`

## Requirements
- R1: While rst_ni is low, and directly after reset with all pins at their idle levels (standby low), enable_o is all zeros.
- R2: With mode_i low and stby_i high, enable_o[i] follows par_i[i]. The bit order is [7]=A-, [6]=A+, [5]=B-, [4]=B+, [3]=C-, [2]=C+, [1]=D-, [0]=D+. So the two inputs of phase A sit at bits 6 (plus) and 7 (minus), and so on down to D. gate_i has no effect in this mode.
- R3: Each rising edge seen on ser_clk_i shifts the register by one place. Stage 0 takes ser_data_i, and stage i takes the old stage i-1.
- R4: The shift register changes on nothing but a rising serial-clock edge. A falling edge, a steady high level and data changes while the clock is high leave it unchanged.
- R5: A rising edge seen on latch_i copies the shift register into the storage register. At all other times, including while latch_i stays high, the storage register holds its value.
- R6: While clr_ni is low, the storage register is zero. The shift register is unaffected, so a later latch restores the shifted byte.
- R7: In serial mode with stby_i high, gate_i high forces enable_o to zero. gate_i low passes the storage register through. The storage register is not altered by gate_i.
- R8: stby_i low forces enable_o to zero in both modes.
- R9: In serial mode, storage bit i drives enable_o[i], using the bit order of R2. After eight shifts, the first bit sent sits at bit 7 (A-) and the last at bit 0 (D+).
- R10: A change on a parallel input appears on enable_o at the second rising clock edge after the change is presented.
- R11: When a latch rise and a serial-clock rise are sampled in the same cycle, the storage register takes the contents from before that shift. When a latch rise and a low clr_ni coincide, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0: parallel source, 1: serial source |
| par_i | input | 8 | Direct enable inputs, bit order per R2 |
| ser_clk_i | input | 1 | Serial shift clock sample, idles low |
| ser_data_i | input | 1 | Serial data sample |
| clr_ni | input | 1 | Active-low storage clear |
| latch_i | input | 1 | Storage load strobe, acts on its rise |
| gate_i | input | 1 | High masks serial-mode enables |
| stby_i | input | 1 | Low forces all enables off |
| enable_o | output | 8 | Registered transistor enables |

## Verification
Two pairs of actions can fall in the same sampled cycle:
- a latch rise together with a serial-clock rise;
- a latch rise together with an asserted clear.

The bench drives both pins on the same falling clock edge, so both edges are detected in one cycle. For the first pair, it then checks that the enables show the byte from before the shift, and that a later latch shows the shifted byte. For the second pair, it checks that the enables stay zero, and that they remain zero after clear is released while latch is still high. A behavioural model compares enable_o on every clock throughout these cases.

// File: rtl/motor_en_pkg.sv
package motor_en_pkg;
  typedef struct packed {
    logic mode;
    logic ser_clk;
    logic ser_data;
    logic clr_n;
    logic latch;
    logic gate;
    logic stby;
  } ctl_t;

  // idle pin levels: everything low except gate (masked)
  localparam ctl_t CTL_IDLE = '{mode: 1'b0, ser_clk: 1'b0, ser_data: 1'b0,
                                clr_n: 1'b0, latch: 1'b0, gate: 1'b1, stby: 1'b0};
endpackage

// File: rtl/mei_pin_sync.sv
module mei_pin_sync
  import motor_en_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctl_t            ctl_i,
  input  logic [CH_W-1:0] par_i,
  output ctl_t            ctl_o,
  output logic [CH_W-1:0] par_o,
  output logic            shift_o,
  output logic            load_o
);
  ctl_t            ctl_q;
  logic [CH_W-1:0] par_q;
  logic            sclk_prev_q, latch_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q        <= CTL_IDLE;
      par_q        <= '0;
      sclk_prev_q  <= 1'b0;
      latch_prev_q <= 1'b0;
    end else begin
      ctl_q        <= ctl_i;
      par_q        <= par_i;
      sclk_prev_q  <= ctl_q.ser_clk;
      latch_prev_q <= ctl_q.latch;
    end
  end

  assign ctl_o   = ctl_q;
  assign par_o   = par_q;
  assign shift_o = ctl_q.ser_clk & ~sclk_prev_q;
  assign load_o  = ctl_q.latch & ~latch_prev_q;
endmodule

// File: rtl/mei_shift_store.sv
module mei_shift_store #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         din_i,
  input  logic         load_i,
  input  logic         clr_ni,
  output logic [W-1:0] store_o
);
  logic [W-1:0] sr_q, st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], din_i};
  end

  // clear has priority over a load in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else if (!clr_ni) st_q <= '0;
    else if (load_i) st_q <= sr_q;
  end

  assign store_o = st_q;

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> st_q == '0);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_i) |=> $stable(st_q));
  assert_sr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q));
endmodule

// File: rtl/mei_out_select.sv
module mei_out_select #(
  parameter int NUM_PHASES = 4,
  localparam int CH_W = 2 * NUM_PHASES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic            gate_i,
  input  logic            stby_i,
  input  logic [CH_W-1:0] par_i,
  input  logic [CH_W-1:0] store_i,
  output logic [CH_W-1:0] en_o
);
  logic [CH_W-1:0] ch_on;
  logic [CH_W-1:0] en_q;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int IDX = 2 * p + s;
      assign ch_on[IDX] = stby_i & (mode_i ? (~gate_i & store_i[IDX]) : par_i[IDX]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else en_q <= ch_on;
  end

  assign en_o = en_q;

  assert_stby_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_i |=> en_o == '0);
  assert_gate_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && gate_i) |=> en_o == '0);
  assert_par_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && stby_i) |=> en_o == $past(par_i));
endmodule

// File: rtl/motor_enable_if.sv
module motor_enable_if
  import motor_en_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  localparam int CH_W = 2 * NUM_PHASES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic [CH_W-1:0] par_i,
  input  logic            ser_clk_i,
  input  logic            ser_data_i,
  input  logic            clr_ni,
  input  logic            latch_i,
  input  logic            gate_i,
  input  logic            stby_i,
  output logic [CH_W-1:0] enable_o
);
  ctl_t            ctl_in, ctl_q;
  logic [CH_W-1:0] par_q, store;
  logic            shift, load;

  assign ctl_in = '{mode: mode_i, ser_clk: ser_clk_i, ser_data: ser_data_i,
                    clr_n: clr_ni, latch: latch_i, gate: gate_i, stby: stby_i};

  mei_pin_sync #(.CH_W(CH_W)) u_sync (
    .clk_i, .rst_ni, .ctl_i(ctl_in), .par_i,
    .ctl_o(ctl_q), .par_o(par_q), .shift_o(shift), .load_o(load)
  );

  mei_shift_store #(.W(CH_W)) u_store (
    .clk_i, .rst_ni, .shift_i(shift), .din_i(ctl_q.ser_data),
    .load_i(load), .clr_ni(ctl_q.clr_n), .store_o(store)
  );

  mei_out_select #(.NUM_PHASES(NUM_PHASES)) u_out (
    .clk_i, .rst_ni, .mode_i(ctl_q.mode), .gate_i(ctl_q.gate),
    .stby_i(ctl_q.stby), .par_i(par_q), .store_i(store), .en_o(enable_o)
  );

  assert_rst_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> enable_o == '0);
endmodule

// File: tb/motor_enable_if_tb.sv
module motor_enable_if_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, sclk = 1'b0, sdata = 1'b0, clr_n = 1'b0, latch = 1'b0;
  logic gate = 1'b1, stby = 1'b0;
  logic [7:0] par = '0;
  logic [7:0] enable;
  int errs = 0, chks = 0;

  always #2 clk = ~clk;

  motor_enable_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .par_i(par),
    .ser_clk_i(sclk), .ser_data_i(sdata), .clr_ni(clr_n), .latch_i(latch),
    .gate_i(gate), .stby_i(stby), .enable_o(enable)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    chks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdata = b; step(2);
    sclk = 1'b1; step(2);
    sclk = 1'b0; step(2);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_latch();
    latch = 1'b1; step(2);
    latch = 1'b0; step(3);
  endtask

  // behavioural reference: integers and previous levels, one sample per clock
  int m_sr, m_st, m_exp, m_chk;
  bit m_pclk, m_plat, m_valid;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sr = 0; m_st = 0; m_exp = 0; m_chk = 0;
      m_pclk = 0; m_plat = 0; m_valid = 0;
    end else begin
      m_chk = m_exp;
      m_valid = 1;
      if (!stby) m_exp = 0;
      else if (!mode) m_exp = int'(par);
      else if (gate) m_exp = 0;
      else m_exp = m_st;
      if (!clr_n) m_st = 0;
      else if (latch && !m_plat) m_st = m_sr;
      if (sclk && !m_pclk) m_sr = ((m_sr << 1) | int'(sdata)) & 8'hFF;
      m_pclk = sclk;
      m_plat = latch;
    end
  end

  always @(negedge clk)
    if (rst_n && m_valid) chk("cycle-model R2 R3 R5 R6 R7 R8", enable, m_chk[7:0]);

  initial begin
    step(3);
    chk("R1 in reset", enable, 8'h00);
    rst_n = 1'b1;
    step(3);
    chk("R1 after reset", enable, 8'h00);

    // parallel mode, gate high has no effect
    stby = 1'b1; clr_n = 1'b1; par = 8'hA5;
    step(4);
    chk("R2 parallel A5 gate high", enable, 8'hA5);
    par = 8'h3C; gate = 1'b0;
    step(4);
    chk("R2 parallel 3C", enable, 8'h3C);
    par = 8'hFF;
    step(1);
    chk("R10 one cycle", enable, 8'h3C);
    step(1);
    chk("R10 two cycles", enable, 8'hFF);
    stby = 1'b0;
    step(4);
    chk("R8 standby parallel", enable, 8'h00);
    stby = 1'b1;

    // serial mode
    mode = 1'b1;
    step(4);
    chk("R6 storage empty", enable, 8'h00);
    send_byte(8'h96);
    pulse_latch();
    chk("R3 R9 serial 96", enable, 8'h96);
    gate = 1'b1;
    step(4);
    chk("R7 gate masks", enable, 8'h00);
    gate = 1'b0;
    step(4);
    chk("R7 gate release keeps storage", enable, 8'h96);

    send_byte(8'h0F);
    chk("R5 no latch holds", enable, 8'h96);
    pulse_latch();
    chk("R5 latch loads 0F", enable, 8'h0F);

    // one rise, long high, data change while high, fall
    sdata = 1'b1; step(2);
    sclk = 1'b1; step(6);
    sdata = 1'b0; step(2);
    sclk = 1'b0; step(4);
    pulse_latch();
    chk("R4 single shift", enable, 8'h1F);

    clr_n = 1'b0;
    step(4);
    chk("R6 clear", enable, 8'h00);
    clr_n = 1'b1;
    step(4);
    chk("R6 cleared held", enable, 8'h00);
    pulse_latch();
    chk("R6 shift reg intact", enable, 8'h1F);

    // latch rise and clock rise in one cycle
    sdata = 1'b0; step(2);
    sclk = 1'b1; latch = 1'b1; step(3);
    sclk = 1'b0; latch = 1'b0; step(3);
    chk("R11 pre-shift content", enable, 8'h1F);
    pulse_latch();
    chk("R11 shifted content", enable, 8'h3E);

    // latch rise with clear in one cycle
    clr_n = 1'b0; latch = 1'b1; step(4);
    chk("R11 clear wins", enable, 8'h00);
    clr_n = 1'b1; step(4);
    chk("R5 latch level no reload", enable, 8'h00);
    latch = 1'b0; step(2);
    pulse_latch();
    chk("R9 reload 3E", enable, 8'h3E);
    stby = 1'b0; step(4);
    chk("R8 standby serial", enable, 8'h00);
    stby = 1'b1; step(4);
    chk("R8 standby release", enable, 8'h3E);

    mode = 1'b0; par = 8'h81; step(4);
    chk("R2 back to parallel", enable, 8'h81);

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    #400000;
    errs++;
    chks++;
    $display("FAIL watchdog: got=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule